// File: doc/BRIEF.md
# Register Bank with Pending-Write Lock Queue

This block is a general-purpose register file with two read ports and one write port. It serves a pipeline whose results return some time after the instruction leaves decode. A busy bit per register is not used. Instead, every issued instruction places its destination register number into a small ordered queue of pending writes. Each read port searches that queue on every access. A read returns data only when its register number is absent from every live queue slot, so a read of an unrelated register goes ahead even when several writes are outstanding.

Write-backs return in issue order. A write-back is accepted only when its register number equals the oldest queue slot. It then updates the storage and retires that slot. When all queue slots hold pending writes, the block lowers its issue-ready signal and refuses further issue. No arbitration is needed, because the queue order alone sets which write retires next.

The queue occupancy is tracked by a three-state machine. The states are Q_EMPTY, Q_PARTIAL and Q_FULL. The named transitions are:
- T_FIRST: Q_EMPTY to Q_PARTIAL, on an issue.
- T_FILL: Q_PARTIAL to Q_FULL, on an issue without a retire while one slot is left.
- T_DRAIN: Q_PARTIAL to Q_EMPTY, on a retire without an issue while one slot is live.
- T_RELEASE: Q_FULL to Q_PARTIAL, on a retire.

Every other case holds the current state, including an issue and a retire in the same cycle.

Top module: `regbank_locked`

## Requirements
- R1: After reset the queue is empty, `iss_ready_o` is 1, and every register reads as zero with valid 1.
- R2: An issue (`iss_valid_i` and `iss_ready_o` both 1) locks register `iss_dst_i` from the next cycle. A read of a locked register gives valid 0.
- R3: A read of a register that is in no live queue slot gives valid 1 and the current contents in the same cycle, even while other writes are pending.
- R4: With LOCK_DEPTH (4) pending writes, `iss_ready_o` is 0. An issue attempted then is ignored and does not lock its register.
- R5: A write-back whose index equals the oldest pending slot stores `wb_data_i` and retires that slot at the clock edge. From the next cycle the register reads valid with the new data. During the write-back cycle itself the read stays stalled.
- R6: A write-back with an empty queue, or with an index other than the oldest pending slot, is ignored. No register changes and no slot retires.
- R7: A register number held in two live slots stays locked until both slots have retired.
- R8: An issue and a retire in the same cycle leave the occupancy unchanged. From Q_FULL, a retire makes `iss_ready_o` 1 in the next cycle.
- R9: The two read ports are independent. One may stall while the other returns valid data in the same cycle.
- R10: A read port with its enable at 0 gives valid 0. Whenever a port's valid is 0, its data output is all zeros.
- R11: A read of the register being issued in the same cycle is not stalled by that issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Issue request carrying a destination register |
| iss_dst_i | input | 4 | Destination register number of the issue |
| iss_ready_o | output | 1 | High when the lock queue can take an issue |
| wb_valid_i | input | 1 | Write-back present |
| wb_idx_i | input | 4 | Register number of the write-back |
| wb_data_i | input | 32 | Write-back data |
| rd_a_en_i | input | 1 | Read port A enable |
| rd_a_idx_i | input | 4 | Read port A register number |
| rd_a_valid_o | output | 1 | Read port A data valid (not locked) |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_en_i | input | 1 | Read port B enable |
| rd_b_idx_i | input | 4 | Read port B register number |
| rd_b_valid_o | output | 1 | Read port B data valid (not locked) |
| rd_b_data_o | output | 32 | Read port B data |

## Verification
The bench targets a register number held in two slots at once. A design that searched only for presence, and cleared the lock on the first retire, would release the read one write too early and return a stale value. It tests write-backs whose index misses the oldest slot, and write-backs that arrive with nothing pending. A design that wrote or retired regardless would corrupt the register or unlock another one. It also tests an issue refused while the queue is full, which a careless design would accept and lose a slot for. Finally it tests issue and retire in one cycle, where a miscounting occupancy would lower ready one issue too soon or too late.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    // Occupancy of the pending-write lock queue
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } lockq_state_e;

    // Number of read ports served by the bank
    localparam int unsigned RD_PORTS = 2;

endpackage

// File: rtl/lock_queue.sv
module lock_queue
    import regbank_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned IDX_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push_req_i,
    input  logic [IDX_W-1:0]       push_idx_i,
    input  logic                   wb_valid_i,
    input  logic [IDX_W-1:0]       wb_idx_i,
    output logic                   ready_o,
    output logic                   pop_o,
    output logic [IDX_W-1:0]       head_idx_o,
    output lockq_state_e           state_o,
    output logic [DEPTH*IDX_W-1:0] slot_idx_o,
    output logic [DEPTH-1:0]       slot_live_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    lockq_state_e     state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [PTR_W-1:0] head_q, tail_q;
    logic [IDX_W-1:0] slot_q [DEPTH];
    logic             not_empty;
    logic             push;

    // Output process: everything the state alone decides
    always_comb begin
        unique case (state_q)
            Q_EMPTY:   begin ready_o = 1'b1; not_empty = 1'b0; end
            Q_PARTIAL: begin ready_o = 1'b1; not_empty = 1'b1; end
            Q_FULL:    begin ready_o = 1'b0; not_empty = 1'b1; end
            default:   begin ready_o = 1'b0; not_empty = 1'b0; end
        endcase
    end

    assign head_idx_o = slot_q[head_q];
    assign push       = push_req_i && ready_o;
    assign pop_o      = wb_valid_i && not_empty && (wb_idx_i == head_idx_o);
    assign state_o    = state_q;

    // Next-state logic with named transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (push) begin
                    state_d = (DEPTH == 1) ? Q_FULL : Q_PARTIAL;      // T_FIRST
                end
            end
            Q_PARTIAL: begin
                if (push && !pop_o && (count_q == CNT_W'(DEPTH - 1))) begin
                    state_d = Q_FULL;                                 // T_FILL
                end else if (pop_o && !push && (count_q == CNT_W'(1))) begin
                    state_d = Q_EMPTY;                                // T_DRAIN
                end
            end
            Q_FULL: begin
                if (pop_o) begin
                    state_d = (DEPTH == 1) ? Q_EMPTY : Q_PARTIAL;     // T_RELEASE
                end
            end
            default: state_d = Q_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Occupancy and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            head_q  <= '0;
            tail_q  <= '0;
        end else begin
            if (push && !pop_o) begin
                count_q <= count_q + CNT_W'(1);
            end else if (pop_o && !push) begin
                count_q <= count_q - CNT_W'(1);
            end
            if (push) begin
                tail_q <= (tail_q == LAST_PTR) ? '0 : tail_q + PTR_W'(1);
            end
            if (pop_o) begin
                head_q <= (head_q == LAST_PTR) ? '0 : head_q + PTR_W'(1);
            end
        end
    end

    // Slot storage and live mask, one copy per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (push && (tail_q == PTR_W'(g))) begin
                slot_q[g] <= push_idx_i;
            end
        end

        always_comb begin
            int off;
            if (g >= int'(head_q)) begin
                off = g - int'(head_q);
            end else begin
                off = g + int'(DEPTH) - int'(head_q);
            end
            slot_live_o[g] = off < int'(count_q);
        end

        assign slot_idx_o[g*IDX_W +: IDX_W] = slot_q[g];
    end

endmodule

// File: rtl/lock_match.sv
module lock_match #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned IDX_W = 4
) (
    input  logic [IDX_W-1:0]       rd_idx_i,
    input  logic [DEPTH*IDX_W-1:0] slot_idx_i,
    input  logic [DEPTH-1:0]       slot_live_i,
    output logic                   locked_o
);

    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = slot_live_i[g] && (slot_idx_i[g*IDX_W +: IDX_W] == rd_idx_i);
    end

    assign locked_o = |hit;

endmodule

// File: rtl/reg_storage.sv
module reg_storage #(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned IDX_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ra_idx_i,
    output logic [DATA_W-1:0] ra_data_o,
    input  logic [IDX_W-1:0]  rb_idx_i,
    output logic [DATA_W-1:0] rb_data_o
);

    logic [DATA_W-1:0] mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (we_i && (widx_i == IDX_W'(g))) begin
                mem[g] <= wdata_i;
            end
        end
    end

    assign ra_data_o = mem[ra_idx_i];
    assign rb_data_o = mem[rb_idx_i];

endmodule

// File: rtl/regbank_locked.sv
module regbank_locked
    import regbank_pkg::*;
#(
    parameter int unsigned NUM_REGS   = 16,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned LOCK_DEPTH = 4,
    parameter int unsigned IDX_W      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid_i,
    input  logic [IDX_W-1:0]  iss_dst_i,
    output logic              iss_ready_o,
    input  logic              wb_valid_i,
    input  logic [IDX_W-1:0]  wb_idx_i,
    input  logic [DATA_W-1:0] wb_data_i,
    input  logic              rd_a_en_i,
    input  logic [IDX_W-1:0]  rd_a_idx_i,
    output logic              rd_a_valid_o,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic              rd_b_en_i,
    input  logic [IDX_W-1:0]  rd_b_idx_i,
    output logic              rd_b_valid_o,
    output logic [DATA_W-1:0] rd_b_data_o
);

    lockq_state_e                 q_state;
    logic                         q_pop;
    logic [IDX_W-1:0]             head_idx;
    logic [LOCK_DEPTH*IDX_W-1:0]  slot_idx;
    logic [LOCK_DEPTH-1:0]        slot_live;
    logic                         store_we;

    logic              rd_en    [RD_PORTS];
    logic [IDX_W-1:0]  rd_idx   [RD_PORTS];
    logic              rd_lock  [RD_PORTS];
    logic [DATA_W-1:0] rd_raw   [RD_PORTS];
    logic              rd_valid [RD_PORTS];
    logic [DATA_W-1:0] rd_data  [RD_PORTS];

    lock_queue #(
        .DEPTH (LOCK_DEPTH),
        .IDX_W (IDX_W)
    ) u_lockq (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_req_i  (iss_valid_i),
        .push_idx_i  (iss_dst_i),
        .wb_valid_i  (wb_valid_i),
        .wb_idx_i    (wb_idx_i),
        .ready_o     (iss_ready_o),
        .pop_o       (q_pop),
        .head_idx_o  (head_idx),
        .state_o     (q_state),
        .slot_idx_o  (slot_idx),
        .slot_live_o (slot_live)
    );

    assign store_we = q_pop;

    reg_storage #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (store_we),
        .widx_i    (wb_idx_i),
        .wdata_i   (wb_data_i),
        .ra_idx_i  (rd_idx[0]),
        .ra_data_o (rd_raw[0]),
        .rb_idx_i  (rd_idx[1]),
        .rb_data_o (rd_raw[1])
    );

    assign rd_en[0]  = rd_a_en_i;
    assign rd_idx[0] = rd_a_idx_i;
    assign rd_en[1]  = rd_b_en_i;
    assign rd_idx[1] = rd_b_idx_i;

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        lock_match #(
            .DEPTH (LOCK_DEPTH),
            .IDX_W (IDX_W)
        ) u_match (
            .rd_idx_i    (rd_idx[p]),
            .slot_idx_i  (slot_idx),
            .slot_live_i (slot_live),
            .locked_o    (rd_lock[p])
        );

        assign rd_valid[p] = rd_en[p] && !rd_lock[p];
        assign rd_data[p]  = rd_valid[p] ? rd_raw[p] : '0;
    end

    assign rd_a_valid_o = rd_valid[0];
    assign rd_a_data_o  = rd_data[0];
    assign rd_b_valid_o = rd_valid[1];
    assign rd_b_data_o  = rd_data[1];

endmodule

// File: rtl/regbank_locked_chk.sv
module regbank_locked_chk
    import regbank_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_valid_i,
    input logic [IDX_W-1:0]  iss_dst_i,
    input logic              iss_ready_o,
    input logic              wb_valid_i,
    input logic [IDX_W-1:0]  wb_idx_i,
    input logic              rd_a_en_i,
    input logic [IDX_W-1:0]  rd_a_idx_i,
    input logic              rd_a_valid_o,
    input logic [DATA_W-1:0] rd_a_data_o,
    input logic              rd_b_en_i,
    input logic [IDX_W-1:0]  rd_b_idx_i,
    input logic              rd_b_valid_o,
    input logic [DATA_W-1:0] rd_b_data_o,
    input lockq_state_e      q_state,
    input logic [IDX_W-1:0]  head_idx,
    input logic              q_pop,
    input logic              store_we
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !past_ok |-> iss_ready_o);

    assert_lock_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(iss_valid_i && iss_ready_o) && rd_a_en_i
         && (rd_a_idx_i == $past(iss_dst_i))) |-> !rd_a_valid_o);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!iss_ready_o && !q_pop)) |-> !iss_ready_o);

    assert_write_only_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |-> (q_state != Q_EMPTY && wb_idx_i == head_idx));

    assert_empty_wb_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_i && q_state == Q_EMPTY) |-> !store_we);

    assert_a_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_a_valid_o |-> (rd_a_data_o == '0));

    assert_b_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_b_valid_o |-> (rd_b_data_o == '0));

    assert_b_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_b_en_i |-> !rd_b_valid_o);

endmodule

bind regbank_locked regbank_locked_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_valid_i  (iss_valid_i),
    .iss_dst_i    (iss_dst_i),
    .iss_ready_o  (iss_ready_o),
    .wb_valid_i   (wb_valid_i),
    .wb_idx_i     (wb_idx_i),
    .rd_a_en_i    (rd_a_en_i),
    .rd_a_idx_i   (rd_a_idx_i),
    .rd_a_valid_o (rd_a_valid_o),
    .rd_a_data_o  (rd_a_data_o),
    .rd_b_en_i    (rd_b_en_i),
    .rd_b_idx_i   (rd_b_idx_i),
    .rd_b_valid_o (rd_b_valid_o),
    .rd_b_data_o  (rd_b_data_o),
    .q_state      (q_state),
    .head_idx     (head_idx),
    .q_pop        (q_pop),
    .store_we     (store_we)
);

// File: tb/regbank_locked_bench.sv
module regbank_locked_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 13;

    typedef struct packed {
        logic [3:0]  rq;
        logic        iv;
        logic [3:0]  id;
        logic        wv;
        logic [3:0]  wi;
        logic [31:0] wd;
        logic        ae;
        logic [3:0]  ai;
        logic        be;
        logic [3:0]  bi;
        logic        xr;
        logic        xav;
        logic [31:0] xad;
        logic        xbv;
        logic [31:0] xbd;
    } vec_t;

    // rq, iss v/dst, wb v/idx/data, rdA en/idx, rdB en/idx, exp ready, exp A v/d, exp B v/d
    localparam vec_t VECS [N_VEC] = '{
        // R11: issue r3, read r3 same cycle not stalled
        '{4'd11, 1'b1, 4'd3, 1'b0, 4'd0, 32'h0,  1'b1, 4'd3, 1'b1, 4'd5, 1'b1, 1'b1, 32'h0,  1'b1, 32'h0},
        // R2: r3 locked now; issue r5, retire r3 with 0x11
        '{4'd2,  1'b1, 4'd5, 1'b1, 4'd3, 32'h11, 1'b1, 4'd3, 1'b1, 4'd7, 1'b1, 1'b0, 32'h0,  1'b1, 32'h0},
        // R5: r3 now valid with new data; r5 locked
        '{4'd5,  1'b0, 4'd0, 1'b0, 4'd0, 32'h0,  1'b1, 4'd3, 1'b1, 4'd5, 1'b1, 1'b1, 32'h11, 1'b0, 32'h0},
        // R3 and R9: A stalls on r5 while B reads r3
        '{4'd3,  1'b0, 4'd0, 1'b1, 4'd5, 32'h22, 1'b1, 4'd5, 1'b1, 4'd3, 1'b1, 1'b0, 32'h0,  1'b1, 32'h11},
        // R5: r5 released
        '{4'd5,  1'b0, 4'd0, 1'b0, 4'd0, 32'h0,  1'b1, 4'd5, 1'b1, 4'd5, 1'b1, 1'b1, 32'h22, 1'b1, 32'h22},
        // R10: A disabled; issue r2
        '{4'd10, 1'b1, 4'd2, 1'b0, 4'd0, 32'h0,  1'b0, 4'd2, 1'b1, 4'd2, 1'b1, 1'b0, 32'h0,  1'b1, 32'h0},
        // R7: second issue of r2
        '{4'd7,  1'b1, 4'd2, 1'b0, 4'd0, 32'h0,  1'b1, 4'd2, 1'b1, 4'd4, 1'b1, 1'b0, 32'h0,  1'b1, 32'h0},
        // R7: first retire of r2
        '{4'd7,  1'b0, 4'd0, 1'b1, 4'd2, 32'h33, 1'b1, 4'd2, 1'b0, 4'd0, 1'b1, 1'b0, 32'h0,  1'b0, 32'h0},
        // R7: r2 still locked by second slot
        '{4'd7,  1'b0, 4'd0, 1'b0, 4'd0, 32'h0,  1'b1, 4'd2, 1'b1, 4'd7, 1'b1, 1'b0, 32'h0,  1'b1, 32'h0},
        // R7: second retire of r2
        '{4'd7,  1'b0, 4'd0, 1'b1, 4'd2, 32'h44, 1'b1, 4'd2, 1'b0, 4'd0, 1'b1, 1'b0, 32'h0,  1'b0, 32'h0},
        // R7: r2 free with final value
        '{4'd7,  1'b0, 4'd0, 1'b0, 4'd0, 32'h0,  1'b1, 4'd2, 1'b1, 4'd2, 1'b1, 1'b1, 32'h44, 1'b1, 32'h44},
        // R6: write-back to r9 with empty queue
        '{4'd6,  1'b0, 4'd0, 1'b1, 4'd9, 32'hDEAD, 1'b1, 4'd9, 1'b1, 4'd3, 1'b1, 1'b1, 32'h0, 1'b1, 32'h11},
        // R6: r9 unchanged
        '{4'd6,  1'b0, 4'd0, 1'b0, 4'd0, 32'h0,  1'b1, 4'd9, 1'b0, 4'd0, 1'b1, 1'b1, 32'h0,  1'b0, 32'h0}
    };

    logic        clk;
    logic        rst_n;
    logic        iss_valid;
    logic [3:0]  iss_dst;
    logic        iss_ready;
    logic        wb_valid;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data;
    logic        a_en, b_en;
    logic [3:0]  a_idx, b_idx;
    logic        a_valid, b_valid;
    logic [31:0] a_data, b_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    regbank_locked u_regbank_locked (
        .clk          (clk),
        .rst_n        (rst_n),
        .iss_valid_i  (iss_valid),
        .iss_dst_i    (iss_dst),
        .iss_ready_o  (iss_ready),
        .wb_valid_i   (wb_valid),
        .wb_idx_i     (wb_idx),
        .wb_data_i    (wb_data),
        .rd_a_en_i    (a_en),
        .rd_a_idx_i   (a_idx),
        .rd_a_valid_o (a_valid),
        .rd_a_data_o  (a_data),
        .rd_b_en_i    (b_en),
        .rd_b_idx_i   (b_idx),
        .rd_b_valid_o (b_valid),
        .rd_b_data_o  (b_data)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    // Apply inputs after a falling edge; outputs are checked before the next rising edge
    task automatic drive(input logic iv, input logic [3:0] id, input logic wv,
                         input logic [3:0] wi, input logic [31:0] wd,
                         input logic ae, input logic [3:0] ai,
                         input logic be, input logic [3:0] bi);
        @(negedge clk);
        iss_valid = iv; iss_dst = id;
        wb_valid  = wv; wb_idx  = wi; wb_data = wd;
        a_en = ae; a_idx = ai; b_en = be; b_idx = bi;
        #1;
    endtask

    task automatic read_a(input string req, input logic [3:0] idx,
                          input logic ev, input logic [31:0] ed);
        drive(1'b0, 4'd0, 1'b0, 4'd0, 32'h0, 1'b1, idx, 1'b0, 4'd0);
        chk(req, $sformatf("read r%0d valid", idx), {31'b0, a_valid}, {31'b0, ev});
        chk(req, $sformatf("read r%0d data", idx), a_data, ed);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        iss_valid = 0; iss_dst = 0; wb_valid = 0; wb_idx = 0; wb_data = 0;
        a_en = 0; a_idx = 0; b_en = 0; b_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 4000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        do_reset();

        // R1: reset state
        drive(1'b0, 4'd0, 1'b0, 4'd0, 32'h0, 1'b1, 4'd0, 1'b1, 4'd15);
        chk("R1", "ready", {31'b0, iss_ready}, 32'h1);
        chk("R1", "A valid r0", {31'b0, a_valid}, 32'h1);
        chk("R1", "A data r0", a_data, 32'h0);
        chk("R1", "B valid r15", {31'b0, b_valid}, 32'h1);
        chk("R1", "B data r15", b_data, 32'h0);

        // Table walk
        for (int k = 0; k < N_VEC; k++) begin
            string tag;
            tag = $sformatf("R%0d step%0d", VECS[k].rq, k);
            drive(VECS[k].iv, VECS[k].id, VECS[k].wv, VECS[k].wi, VECS[k].wd,
                  VECS[k].ae, VECS[k].ai, VECS[k].be, VECS[k].bi);
            chk(tag, "ready", {31'b0, iss_ready}, {31'b0, VECS[k].xr});
            chk(tag, "A valid", {31'b0, a_valid}, {31'b0, VECS[k].xav});
            chk(tag, "A data", a_data, VECS[k].xad);
            chk(tag, "B valid", {31'b0, b_valid}, {31'b0, VECS[k].xbv});
            chk(tag, "B data", b_data, VECS[k].xbd);
        end

        // R4: fill the queue with r1, r4, r6, r8
        drive(1'b1, 4'd1, 1'b0, 4'd0, 32'h0, 1'b0, 4'd0, 1'b0, 4'd0);
        chk("R4", "ready with 0 pending", {31'b0, iss_ready}, 32'h1);
        drive(1'b1, 4'd4, 1'b0, 4'd0, 32'h0, 1'b0, 4'd0, 1'b0, 4'd0);
        drive(1'b1, 4'd6, 1'b0, 4'd0, 32'h0, 1'b0, 4'd0, 1'b0, 4'd0);
        drive(1'b1, 4'd8, 1'b0, 4'd0, 32'h0, 1'b0, 4'd0, 1'b0, 4'd0);
        chk("R4", "ready with 3 pending", {31'b0, iss_ready}, 32'h1);
        // R4: full now; issue of r10 must be refused
        drive(1'b1, 4'd10, 1'b0, 4'd0, 32'h0, 1'b1, 4'd8, 1'b0, 4'd0);
        chk("R4", "ready when full", {31'b0, iss_ready}, 32'h0);
        chk("R2", "r8 locked", {31'b0, a_valid}, 32'h0);
        // R6: write-back to r6 while r1 is oldest: ignored
        drive(1'b0, 4'd0, 1'b1, 4'd6, 32'h66, 1'b0, 4'd0, 1'b0, 4'd0);
        chk("R4", "ready still low", {31'b0, iss_ready}, 32'h0);
        drive(1'b0, 4'd0, 1'b0, 4'd0, 32'h0, 1'b1, 4'd1, 1'b0, 4'd0);
        chk("R6", "ready after mismatched wb", {31'b0, iss_ready}, 32'h0);
        chk("R6", "r1 still locked", {31'b0, a_valid}, 32'h0);
        // R8: retire from full with a refused issue in the same cycle
        drive(1'b1, 4'd11, 1'b1, 4'd1, 32'h101, 1'b1, 4'd1, 1'b0, 4'd0);
        chk("R5", "r1 stalled during its write-back", {31'b0, a_valid}, 32'h0);
        drive(1'b0, 4'd0, 1'b0, 4'd0, 32'h0, 1'b1, 4'd1, 1'b1, 4'd6);
        chk("R8", "ready after retire from full", {31'b0, iss_ready}, 32'h1);
        chk("R5", "r1 data", a_data, 32'h101);
        chk("R9", "r6 still locked on B", {31'b0, b_valid}, 32'h0);
        // Drain r4, r6, r8
        drive(1'b0, 4'd0, 1'b1, 4'd4, 32'h104, 1'b0, 4'd0, 1'b0, 4'd0);
        drive(1'b0, 4'd0, 1'b1, 4'd6, 32'h106, 1'b0, 4'd0, 1'b0, 4'd0);
        drive(1'b0, 4'd0, 1'b1, 4'd8, 32'h108, 1'b0, 4'd0, 1'b0, 4'd0);
        read_a("R6", 4'd6, 1'b1, 32'h106);
        read_a("R4", 4'd10, 1'b1, 32'h0);
        read_a("R4", 4'd11, 1'b1, 32'h0);
        read_a("R5", 4'd8, 1'b1, 32'h108);

        // R8: issue and retire in one cycle keep occupancy
        drive(1'b1, 4'd12, 1'b0, 4'd0, 32'h0, 1'b0, 4'd0, 1'b0, 4'd0);
        drive(1'b1, 4'd13, 1'b1, 4'd12, 32'h112, 1'b0, 4'd0, 1'b0, 4'd0);
        drive(1'b1, 4'd14, 1'b0, 4'd0, 32'h0, 1'b0, 4'd0, 1'b0, 4'd0);
        drive(1'b1, 4'd15, 1'b0, 4'd0, 32'h0, 1'b0, 4'd0, 1'b0, 4'd0);
        drive(1'b1, 4'd0, 1'b0, 4'd0, 32'h0, 1'b1, 4'd12, 1'b0, 4'd0);
        chk("R8", "ready with 3 pending", {31'b0, iss_ready}, 32'h1);
        chk("R8", "r12 retired valid", {31'b0, a_valid}, 32'h1);
        chk("R8", "r12 data", a_data, 32'h112);
        drive(1'b0, 4'd0, 1'b0, 4'd0, 32'h0, 1'b1, 4'd13, 1'b0, 4'd0);
        chk("R8", "ready with 4 pending", {31'b0, iss_ready}, 32'h0);
        chk("R2", "r13 locked", {31'b0, a_valid}, 32'h0);

        // R1: reset mid-run clears queue and storage
        do_reset();
        drive(1'b0, 4'd0, 1'b0, 4'd0, 32'h0, 1'b1, 4'd12, 1'b1, 4'd13);
        chk("R1", "ready after reset", {31'b0, iss_ready}, 32'h1);
        chk("R1", "r12 after reset", a_data, 32'h0);
        chk("R1", "r13 unlocked after reset", {31'b0, b_valid}, 32'h1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule